// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-driven master for IEEE 802.3 Clause 45 station management. Software reaches four 32-bit registers through a single-cycle synchronous read/write port: a status register (MDC divider, busy, read error), a control register (port address, device address, read trigger), an address register and a data register. Each of the three frame kinds is started by a different register access. Writing the address register sends an address frame. Writing the data register sends a write frame. Writing the control register with its read trigger set sends a read frame.

Every frame is 64 MDC periods long. It has a 32-bit preamble of ones, then start `00`, a 2-bit opcode (address `00`, write `01`, read `11`), a 5-bit port address, a 5-bit device address, a 2-bit turnaround and a 16-bit payload, all sent MSB first. During a read the master releases the line for the turnaround and the payload. It takes the 16 payload bits into the data register. It flags an error when the responder fails to pull the second turnaround bit low. Software then treats the data as invalid.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset the status register reads 0x0000_6400 (divider 100, busy 0, error 0), the control, address and data registers read 0, and mdc_o and mdio_oe_o are low.
- R2: Register offsets are 0 status, 1 control, 2 address and 3 data. Status holds the divider in bits [15:8], the read error in bit 1 and busy in bit 0. Control holds the port address in [4:0] and the device address in [12:8]. Its read trigger is bit 15 and always reads 0. Address holds [15:0]. Data holds [15:0] and shows busy in bit 31.
- R3: Writing the address register stores bits [15:0] and sends the 64-bit frame {32 ones, 00, 00, port, device, 10, value}, MSB first.
- R4: Writing the data register stores bits [15:0] and sends the same frame with opcode 01. The master drives all 64 bits.
- R5: A control write with bit 15 set stores the new port and device addresses and sends a read frame with opcode 11 that uses them. mdio_oe_o is low for bits 46 to 63, and the 16 sampled bits land in data [15:0].
- R6: The read error sets when the second turnaround bit (bit 47) is sampled high. The line bits are still captured, so an absent responder on a pulled-up line yields 0xFFFF. The next read that sees a low bit 47 clears the error.
- R7: The MDC half-period is (divider+1) system clocks, and MDC stays low while idle.
- R8: mdio_o changes only while MDC is low (on its falling edges). mdio_i is sampled on MDC rising edges.
- R9: Busy reads 1 in both status bit 0 and data bit 31 from the cycle after the starting write until the frame's 64th MDC falling edge.
- R10: Any register write accepted while busy is discarded. It starts no frame and changes no stored value.
- R11: rdata_o follows addr_i combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data in |

## Verification
Register values appear on rdata_o in the same cycle as addr_i, and the bench sets the address and samples 1 ns later. Busy is due in the cycle after a write is accepted, so the bench reads it right after releasing the strobe. A frame completes 64 × 2 × (divider+1) clocks after the start, and the bench polls busy at falling system-clock edges before it compares the stored register and frame contents. The bench captures frame bits, enable bits and half-period lengths on MDC rising edges, the same instants at which the master samples. Its responder model changes mdio_i on MDC falling edges.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;
  typedef enum logic [1:0] {
    OP_ADDR = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b11
  } mdio_op_e;

  localparam logic [1:0] OFS_STAT = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_ADDR = 2'd2;
  localparam logic [1:0] OFS_DATA = 2'd3;

  localparam int BODY_LEN = 32;
  localparam int PHY_W    = 5;
  localparam int DEV_W    = 5;
  localparam int PAY_W    = 16;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == div_i);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_c45_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  mdio_op_e         op_i,
  input  logic [PHY_W-1:0] prtad_i,
  input  logic [DEV_W-1:0] devad_i,
  input  logic [PAY_W-1:0] payload_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             mdio_i,
  output logic             busy_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  output logic             rd_done_o,
  output logic [PAY_W-1:0] rd_data_o,
  output logic             rd_err_o
);
  localparam int FRAME_LEN = PRE_LEN + BODY_LEN;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_IDX    = PRE_LEN + 14;
  localparam logic [IDX_W-1:0] LAST   = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA2    = IDX_W'(TA_IDX + 1);
  localparam logic [IDX_W-1:0] TA1    = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] PRE_IX = IDX_W'(PRE_LEN);

  logic                busy_q, is_rd_q, ta_bad_q;
  logic [IDX_W-1:0]    idx_q, bidx;
  logic [BODY_LEN-1:0] tx_q;
  logic [PAY_W-1:0]    rx_q;
  logic                rise, fall, done;

  mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_q),
    .div_i (div_i),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign bidx      = LAST - idx_q;
  assign mdio_o    = (idx_q < PRE_IX) ? 1'b1 : tx_q[bidx[4:0]];
  assign mdio_oe_o = busy_q && !(is_rd_q && idx_q >= TA1);
  assign done      = busy_q && fall && (idx_q == LAST);
  assign rd_done_o = done && is_rd_q;
  assign rd_data_o = rx_q;
  assign rd_err_o  = ta_bad_q;
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      is_rd_q  <= 1'b0;
      ta_bad_q <= 1'b0;
      idx_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else if (start_i && !busy_q) begin
      busy_q   <= 1'b1;
      is_rd_q  <= (op_i == OP_RD);
      ta_bad_q <= 1'b0;
      idx_q    <= '0;
      tx_q     <= {2'b00, op_i, prtad_i, devad_i, 2'b10, payload_i};
    end else if (busy_q) begin
      if (rise && is_rd_q) begin
        if (idx_q == TA2) ta_bad_q <= mdio_i;
        if (idx_q > TA2)  rx_q     <= {rx_q[PAY_W-2:0], mdio_i};
      end
      if (fall) begin
        if (idx_q == LAST) busy_q <= 1'b0;
        else               idx_q  <= idx_q + 1'b1;
      end
    end
  end

  // R8
  mdio_rise_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> $stable(mdio_o));
  // R7
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !mdc_o);
  // R9
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(idx_q) == LAST);
  // R5
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 100,
  parameter int PRE_LEN = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [DIV_W-1:0] div_q;
  logic [PHY_W-1:0] prtad_q;
  logic [DEV_W-1:0] devad_q;
  logic [PAY_W-1:0] addr_q, data_q, rd_data;
  logic             err_q, busy, wr_ok, start, rd_done, rd_err;
  mdio_op_e         op;
  logic [PHY_W-1:0] st_prt;
  logic [DEV_W-1:0] st_dev;
  logic [PAY_W-1:0] st_pay;

  assign wr_ok = req_i && we_i && !busy;

  always_comb begin
    start  = 1'b0;
    op     = OP_ADDR;
    st_prt = prtad_q;
    st_dev = devad_q;
    st_pay = wdata_i[PAY_W-1:0];
    if (wr_ok) begin
      unique case (addr_i)
        OFS_ADDR: start = 1'b1;
        OFS_DATA: begin start = 1'b1; op = OP_WR; end
        OFS_CTRL: begin
          start  = wdata_i[15];
          op     = OP_RD;
          st_prt = wdata_i[PHY_W-1:0];
          st_dev = wdata_i[8 +: DEV_W];
          st_pay = '0;
        end
        default: ;
      endcase
    end
  end

  mdio_frame_eng #(.PRE_LEN(PRE_LEN), .DIV_W(DIV_W)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .op_i     (op),
    .prtad_i  (st_prt),
    .devad_i  (st_dev),
    .payload_i(st_pay),
    .div_i    (div_q),
    .mdio_i   (mdio_i),
    .busy_o   (busy),
    .mdc_o    (mdc_o),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o),
    .rd_done_o(rd_done),
    .rd_data_o(rd_data),
    .rd_err_o (rd_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= DIV_W'(DIV_RST);
      prtad_q <= '0;
      devad_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (wr_ok) begin
        unique case (addr_i)
          OFS_STAT: div_q <= wdata_i[8 +: DIV_W];
          OFS_CTRL: begin
            prtad_q <= wdata_i[PHY_W-1:0];
            devad_q <= wdata_i[8 +: DEV_W];
          end
          OFS_ADDR: addr_q <= wdata_i[PAY_W-1:0];
          OFS_DATA: data_q <= wdata_i[PAY_W-1:0];
          default: ;
        endcase
      end
      if (rd_done) begin
        data_q <= rd_data;
        err_q  <= rd_err;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_STAT: begin
        rdata_o[8 +: DIV_W] = div_q;
        rdata_o[1]          = err_q;
        rdata_o[0]          = busy;
      end
      OFS_CTRL: begin
        rdata_o[PHY_W-1:0]  = prtad_q;
        rdata_o[8 +: DEV_W] = devad_q;
      end
      OFS_ADDR: rdata_o[PAY_W-1:0] = addr_q;
      default: begin
        rdata_o[PAY_W-1:0] = data_q;
        rdata_o[31]        = busy;
      end
    endcase
  end

  // R10
  busy_wr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && req_i && we_i && !rd_done) |=> ($stable(data_q) && $stable(addr_q) && $stable(div_q)));
  // R9
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy);
endmodule

// File: tb/sim_mdio_c45_master.sv
module sim_mdio_c45_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  always #10 clk = ~clk;

  mdio_c45_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .mdc_o(mdc_o), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  int vec = 0, bad = 0, rises = 0, base = 0, r8_bad = 0;
  longint cyc = 0, last_rise = 0, half2 = 0;
  logic [63:0] cap = '0, oe_cap = '0;
  logic phy_on = 1'b0;
  logic [15:0] phy_val = '0;
  logic pm = 1'b0, pd = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge mdc_o) begin
    cap    <= {cap[62:0], mdio_o};
    oe_cap <= {oe_cap[62:0], mdio_oe_o};
    rises  <= rises + 1;
    half2  <= cyc - last_rise;
    last_rise <= cyc;
  end

  function automatic logic drive(int n);
    if (!phy_on) return 1'b1;
    if (n == 47) return 1'b0;
    if (n >= 48 && n <= 63) return phy_val[63-n];
    return 1'b1;
  endfunction

  always @(negedge mdc_o) mdio_i <= drive(rises - base);

  always @(negedge clk) begin
    if (mdc_o && pm && (mdio_o !== pd)) r8_bad <= r8_bad + 1;
    pm <= mdc_o;
    pd <= mdio_o;
  end

  function automatic logic [63:0] fr(logic [1:0] op, logic [4:0] p, logic [4:0] d, logic [15:0] v);
    return {32'hFFFF_FFFF, 2'b00, op, p, d, 2'b10, v};
  endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      peek(2'd0, s);
      if (!s[0]) return;
    end
    chk("R9 busy timeout", 1, 0);
  endtask

  always @(posedge clk) if (cyc == 150000) begin
    bad++;
    $display("FAIL watchdog act=%0d exp=idle", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(2'd0, v); chk("R1 status", v, 32'h0000_6400);
    peek(2'd1, v); chk("R1 control", v, 0);
    peek(2'd2, v); chk("R1 address", v, 0);
    peek(2'd3, v); chk("R1 data", v, 0);
    chk("R1 mdc/oe", {mdc_o, mdio_oe_o}, 0);

    // R3 address frame at reset divider
    wr(2'd1, 32'h0000_0105);
    base = rises;
    wr(2'd2, 32'h0000_0ABC);
    peek(2'd0, v); chk("R9 status busy", v[0], 1);
    peek(2'd3, v); chk("R9 data busy", v[31], 1);
    wait_idle();
    chk("R3 frame", cap, fr(2'b00, 5'h05, 5'h01, 16'h0ABC));
    chk("R3 bit count", rises - base, 64);
    chk("R7 half period div100", half2, 202);
    peek(2'd2, v); chk("R2 address readback", v, 32'h0000_0ABC);
    peek(2'd1, v); chk("R11 control same cycle", v, 32'h0000_0105);

    // R4 write frame, divider 1
    wr(2'd0, 32'h0000_0100);
    peek(2'd0, v); chk("R2 status divider", v, 32'h0000_0100);
    base = rises;
    wr(2'd3, 32'h0000_BEEF);
    wait_idle();
    chk("R4 frame", cap, fr(2'b01, 5'h05, 5'h01, 16'hBEEF));
    chk("R4 drive all", oe_cap, 64'hFFFF_FFFF_FFFF_FFFF);
    peek(2'd3, v); chk("R4 data readback", v, 32'h0000_BEEF);

    // R5 read frame with responder
    phy_on = 1'b1; phy_val = 16'hA5C3;
    base = rises;
    wr(2'd1, 32'h0000_831F);
    wait_idle();
    chk("R5 header", cap[63:18], fr(2'b11, 5'h1F, 5'h03, 16'h0)>>18);
    chk("R5 release", oe_cap, {{46{1'b1}}, 18'h0});
    peek(2'd3, v); chk("R5 read data", v, 32'h0000_A5C3);
    peek(2'd0, v); chk("R6 no error", v, 32'h0000_0100);
    peek(2'd1, v); chk("R2 trigger reads 0", v, 32'h0000_031F);

    // R6 absent responder
    phy_on = 1'b0;
    base = rises;
    wr(2'd1, 32'h0000_831F);
    wait_idle();
    peek(2'd0, v); chk("R6 error set", v, 32'h0000_0102);
    peek(2'd3, v); chk("R6 data ones", v, 32'h0000_FFFF);
    phy_on = 1'b1; phy_val = 16'h0001;
    base = rises;
    wr(2'd1, 32'h0000_831F);
    wait_idle();
    peek(2'd0, v); chk("R6 error cleared", v, 32'h0000_0100);
    peek(2'd3, v); chk("R6 data after clear", v, 32'h0000_0001);

    // R10 writes while busy dropped
    base = rises;
    wr(2'd3, 32'h0000_1111);
    wr(2'd3, 32'h0000_2222);
    wr(2'd2, 32'h0000_7777);
    wr(2'd0, 32'h0000_0500);
    wr(2'd1, 32'h0000_8000);
    wait_idle();
    chk("R10 single frame", rises - base, 64);
    chk("R10 frame", cap, fr(2'b01, 5'h1F, 5'h03, 16'h1111));
    peek(2'd3, v); chk("R10 data", v, 32'h0000_1111);
    peek(2'd2, v); chk("R10 address", v, 32'h0000_0ABC);
    peek(2'd0, v); chk("R10 status", v, 32'h0000_0100);
    peek(2'd1, v); chk("R10 control", v, 32'h0000_031F);

    // R7 sweep dividers and addresses
    for (int dv = 0; dv < 4; dv++) begin
      for (int k = 0; k < 4; k++) begin
        logic [4:0] p, d;
        logic [15:0] rg;
        p  = 5'(k * 7 + 3);
        d  = p ^ 5'h1B;
        rg = 16'(16'h5A00 + dv * 16 + k);
        wr(2'd0, 32'(dv) << 8);
        wr(2'd1, {19'h0, d, 3'h0, p});
        base = rises;
        wr(2'd2, {16'h0, rg});
        wait_idle();
        chk("R3 sweep frame", cap, fr(2'b00, p, d, rg));
        chk("R7 sweep half period", half2, 64'(2 * (dv + 1)));
        chk("R7 idle mdc", mdc_o, 0);
      end
    end

    chk("R8 mdio steady while mdc high", r8_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule